// File: doc/BRIEF.md
# Paired-Fetch Branch Predictor with Return Stack

This block sits in the fetch stage of a core that decodes two instructions per cycle. Each cycle the fetch unit can present one aligned pair: the address of the first instruction, and for each of the two slots a small pre-decoded descriptor. The descriptor says whether the slot holds a branch, whether that branch links (a call), whether the instruction loads the program counter from memory, and which register supplies its base or target. Register code 15 marks a PC-relative (direct) branch. Code 14 is the link register. Code 13 is the stack pointer. The predictor picks the first control-transfer instruction in the pair, forms a prediction for it, and one cycle later reports whether fetch should jump and where the next fetch starts.

Direct and indirect branches are predicted by a direct-mapped table of 2-bit saturating counters. Each entry holds a tag and a stored target, and the table is indexed by PC bits [7:2]. Calls push their return address onto a circular 8-entry stack. Returns pop it: these are a jump through the link register, or a PC load based on the stack pointer. The execute stage sends resolved branches back through a resolution port. A resolution trains the table. If it is flagged as a mispredict, it also rewinds the stack pointer and depth to the checkpoint that was reported with that branch's prediction, and the prediction made in that same cycle is discarded.

Top module: `bpred_top`

## Requirements
- R1: After reset `pred_valid` is 0, the history table holds no valid entry and the return stack is empty.
- R2: A branch whose PC misses in the history table is predicted not taken, and the next fetch address is sequential: `fetch_pc + 8`, or `fetch_pc + 4` under the rule of R7.
- R3: A resolution allocates or retrains the entry at PC[7:2]. A miss allocates counter 2 when taken and 1 when not taken. A hit moves the counter up or down, saturating at 0 and 3. A lookup hits only when the full upper PC matches the stored tag. A hit with counter 2 or 3 is predicted taken to the stored target.
- R4: A slot with branch and call set pushes that slot's PC + 4 onto the return stack. Its direction is predicted from the table.
- R5: A non-call branch with base register 14, or a PC load with base register 13, is predicted taken to the top of the return stack and pops it, in last-in-first-out order.
- R6: A non-call branch or PC load through any other base register (not 13, 14 or 15) neither pushes nor pops the stack, and it is predicted from the table.
- R7: Only the first valid control instruction of the pair is predicted. A control instruction in slot 1 behind one in slot 0 has no effect on the stack. If slot 0 is then predicted not taken, the next fetch address is `fetch_pc + 4`, so that slot 1 is fetched again. Slots whose valid bit is clear are ignored.
- R8: The stack holds 8 return addresses. A ninth push overwrites the oldest entry, so that after nine calls eight returns come back in reverse order and the next return finds the stack empty.
- R9: A return seen with an empty stack is predicted not taken, with the sequential next address, and leaves the stack unchanged.
- R10: A resolution with `res_mispredict` set restores the stack pointer and depth from `res_ckpt`. The pair presented in that cycle produces no prediction. `pred_ckpt` carries the stack state that follows the predicted instruction.
- R11: A prediction appears on the outputs exactly one cycle after an accepted pair. With `in_valid` low, no prediction is emitted and the stack does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A pair is presented this cycle |
| fetch_pc | input | 32 | Address of slot 0; slot 1 is at +4 |
| slot_valid | input | 2 | Per-slot instruction present (bit i = slot i) |
| slot_branch | input | 2 | Per-slot branch instruction |
| slot_call | input | 2 | Per-slot branch that links |
| slot_ldpc | input | 2 | Per-slot load whose destination is the PC |
| slot_base | input | 8 | Per-slot base/target register code, 4 bits each, slot 0 in [3:0] |
| res_valid | input | 1 | Resolved branch from execute |
| res_pc | input | 32 | Address of the resolved branch |
| res_taken | input | 1 | Resolved direction |
| res_target | input | 32 | Resolved target address |
| res_mispredict | input | 1 | The resolved branch was mispredicted |
| res_ckpt | input | 7 | Stack checkpoint returned with the branch |
| pred_valid | output | 1 | Prediction valid |
| pred_taken | output | 1 | Fetch is redirected |
| pred_slot | output | 1 | Slot that was predicted |
| pred_next_pc | output | 32 | Next fetch address |
| pred_ckpt | output | 7 | Stack state after this prediction |

## Verification
The hardest state to reach is a mispredict rewind that has to bring back a return address that was already consumed. To get there, the stimulus pushes a call, captures the checkpoint reported with it, and pops that entry with a return. It then sends a mispredict carrying the saved checkpoint in the same cycle as a fresh pair. The bench checks that this pair is dropped and that the next return again predicts the popped address. Stack wrap-around is reached by nine back-to-back calls followed by nine returns, and counter saturation by repeated resolutions of one PC.

// File: rtl/bpred_pkg.sv
package bpred_pkg;

    localparam int unsigned AW = 32;
    localparam int unsigned RW = 4;

    typedef logic [AW-1:0] addr_t;
    typedef logic [RW-1:0] reg_t;

    localparam reg_t REG_SP = reg_t'(13);
    localparam reg_t REG_LR = reg_t'(14);
    localparam reg_t REG_PC = reg_t'(15);

    typedef enum logic [2:0] {
        K_NONE,
        K_DIRECT,
        K_INDIRECT,
        K_CALL,
        K_RETURN
    } kind_e;

    typedef struct packed {
        logic valid;
        logic branch;
        logic call;
        logic ldpc;
        reg_t base;
    } slot_t;

    typedef struct packed {
        logic  hit;
        logic  taken;
        addr_t target;
    } bht_rd_t;

    // Decide how one pre-decoded slot interacts with prediction.
    function automatic kind_e classify(slot_t s);
        if (!s.valid)                       return K_NONE;
        if (s.branch && s.call)             return K_CALL;
        if (s.branch && s.base == REG_LR)   return K_RETURN;
        if (s.ldpc && s.base == REG_SP)     return K_RETURN;
        if (s.branch && s.base == REG_PC)   return K_DIRECT;
        if (s.branch || s.ldpc)             return K_INDIRECT;
        return K_NONE;
    endfunction

    function automatic logic [1:0] ctr_step(logic [1:0] c, logic t);
        if (t) return (c == 2'd3) ? 2'd3 : c + 2'd1;
        return (c == 2'd0) ? 2'd0 : c - 2'd1;
    endfunction

    function automatic logic [1:0] ctr_alloc(logic t);
        return t ? 2'd2 : 2'd1;
    endfunction

endpackage

// File: rtl/bpred_bht.sv
module bpred_bht
    import bpred_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int NRD     = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  addr_t   rd_pc [NRD],
    output bht_rd_t rd    [NRD],
    input  logic    upd_valid,
    input  addr_t   upd_pc,
    input  logic    upd_taken,
    input  addr_t   upd_target
);

    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = AW - IDX_W;

    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [TAG_W-1:0] tag_t;

    function automatic idx_t idx_of(addr_t pc);
        return pc[IDX_W+1:2];
    endfunction

    function automatic tag_t tag_of(addr_t pc);
        return {pc[AW-1:IDX_W+2], pc[1:0]};
    endfunction

    logic [ENTRIES-1:0] vld;
    tag_t               tag_m [ENTRIES];
    logic [1:0]         ctr_m [ENTRIES];
    addr_t              tgt_m [ENTRIES];

    idx_t upd_idx;
    tag_t upd_tag;
    logic upd_hit;

    always_comb begin
        upd_idx = idx_of(upd_pc);
        upd_tag = tag_of(upd_pc);
        upd_hit = vld[upd_idx] && (tag_m[upd_idx] == upd_tag);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld <= '0;
        end else if (upd_valid) begin
            vld[upd_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (upd_valid) begin
            tag_m[upd_idx] <= upd_tag;
            ctr_m[upd_idx] <= upd_hit ? ctr_step(ctr_m[upd_idx], upd_taken)
                                      : ctr_alloc(upd_taken);
            if (upd_taken || !upd_hit) begin
                tgt_m[upd_idx] <= upd_target;
            end
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        idx_t ri;
        always_comb begin
            ri           = idx_of(rd_pc[g]);
            rd[g].hit    = vld[ri] && (tag_m[ri] == tag_of(rd_pc[g]));
            rd[g].taken  = ctr_m[ri][1];
            rd[g].target = tgt_m[ri];
        end
    end

endmodule

// File: rtl/bpred_ras.sv
module bpred_ras
    import bpred_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int PTR_W = $clog2(DEPTH),
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  addr_t            push_addr,
    input  logic             pop,
    input  logic             restore,
    input  logic [PTR_W-1:0] restore_ptr,
    input  logic [CNT_W-1:0] restore_cnt,
    output addr_t            top_addr,
    output logic             empty,
    output logic [PTR_W-1:0] cur_ptr,
    output logic [CNT_W-1:0] cur_cnt,
    output logic [PTR_W-1:0] nxt_ptr,
    output logic [CNT_W-1:0] nxt_cnt
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    addr_t            mem [DEPTH];
    logic [PTR_W-1:0] ptr_up;
    logic [PTR_W-1:0] ptr_dn;

    always_comb begin
        ptr_up = (cur_ptr == LAST) ? '0 : cur_ptr + 1'b1;
        ptr_dn = (cur_ptr == '0) ? LAST : cur_ptr - 1'b1;
        empty  = (cur_cnt == '0);
        top_addr = mem[cur_ptr];

        nxt_ptr = cur_ptr;
        nxt_cnt = cur_cnt;
        if (restore) begin
            nxt_ptr = restore_ptr;
            nxt_cnt = restore_cnt;
        end else if (push) begin
            nxt_ptr = ptr_up;
            nxt_cnt = (cur_cnt == FULL) ? FULL : cur_cnt + 1'b1;
        end else if (pop && !empty) begin
            nxt_ptr = ptr_dn;
            nxt_cnt = cur_cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_ptr <= '0;
            cur_cnt <= '0;
        end else begin
            cur_ptr <= nxt_ptr;
            cur_cnt <= nxt_cnt;
        end
    end

    always_ff @(posedge clk) begin
        if (push && !restore) begin
            mem[ptr_up] <= push_addr;
        end
    end

endmodule

// File: rtl/bpred_select.sv
module bpred_select
    import bpred_pkg::*;
#(
    parameter int NSLOT  = 2,
    parameter int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  slot_t             slots [NSLOT],
    input  addr_t             pc,
    input  bht_rd_t           bht   [NSLOT],
    input  logic              ras_empty,
    input  addr_t             ras_top,
    output logic [SLOT_W-1:0] slot_idx,
    output logic              taken,
    output addr_t             next_pc,
    output logic              push,
    output addr_t             push_addr,
    output logic              pop
);

    kind_e   kind [NSLOT];
    logic    found;
    logic    later;
    kind_e   sel_kind;
    bht_rd_t sel_bht;
    addr_t   tgt;

    for (genvar g = 0; g < NSLOT; g++) begin : g_cls
        assign kind[g] = classify(slots[g]);
    end

    always_comb begin
        found    = 1'b0;
        later    = 1'b0;
        slot_idx = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (kind[i] != K_NONE) begin
                if (!found) begin
                    found    = 1'b1;
                    slot_idx = SLOT_W'(i);
                end else begin
                    later = 1'b1;
                end
            end
        end

        sel_kind = found ? kind[slot_idx] : K_NONE;
        sel_bht  = bht[slot_idx];

        push  = 1'b0;
        pop   = 1'b0;
        taken = 1'b0;
        tgt   = sel_bht.target;
        unique case (sel_kind)
            K_RETURN: begin
                pop   = !ras_empty;
                taken = !ras_empty;
                tgt   = ras_top;
            end
            K_CALL: begin
                push  = 1'b1;
                taken = sel_bht.hit && sel_bht.taken;
            end
            K_DIRECT, K_INDIRECT: begin
                taken = sel_bht.hit && sel_bht.taken;
            end
            default: ;
        endcase

        push_addr = pc + ((addr_t'(slot_idx) + addr_t'(1)) << 2);
        if (taken)      next_pc = tgt;
        else if (later) next_pc = push_addr;
        else            next_pc = pc + addr_t'(4 * NSLOT);
    end

endmodule

// File: rtl/bpred_top.sv
module bpred_top
    import bpred_pkg::*;
#(
    parameter int NSLOT       = 2,
    parameter int BHT_ENTRIES = 64,
    parameter int RAS_DEPTH   = 8,
    parameter int PTR_W       = $clog2(RAS_DEPTH),
    parameter int CNT_W       = $clog2(RAS_DEPTH + 1),
    parameter int CKPT_W      = PTR_W + CNT_W,
    parameter int SLOT_W      = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [AW-1:0]       fetch_pc,
    input  logic [NSLOT-1:0]    slot_valid,
    input  logic [NSLOT-1:0]    slot_branch,
    input  logic [NSLOT-1:0]    slot_call,
    input  logic [NSLOT-1:0]    slot_ldpc,
    input  logic [NSLOT*RW-1:0] slot_base,
    input  logic                res_valid,
    input  logic [AW-1:0]       res_pc,
    input  logic                res_taken,
    input  logic [AW-1:0]       res_target,
    input  logic                res_mispredict,
    input  logic [CKPT_W-1:0]   res_ckpt,
    output logic                pred_valid,
    output logic                pred_taken,
    output logic [SLOT_W-1:0]   pred_slot,
    output logic [AW-1:0]       pred_next_pc,
    output logic [CKPT_W-1:0]   pred_ckpt
);

    slot_t   slots [NSLOT];
    addr_t   rd_pc [NSLOT];
    bht_rd_t bht_rd [NSLOT];

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        always_comb begin
            slots[g].valid  = slot_valid[g];
            slots[g].branch = slot_branch[g];
            slots[g].call   = slot_call[g];
            slots[g].ldpc   = slot_ldpc[g];
            slots[g].base   = slot_base[g*RW +: RW];
            rd_pc[g]        = fetch_pc + addr_t'(4 * g);
        end
    end

    logic flush;
    logic accept;
    assign flush  = res_valid && res_mispredict;
    assign accept = in_valid && !flush;

    bpred_bht #(
        .ENTRIES (BHT_ENTRIES),
        .NRD     (NSLOT)
    ) u_bht (
        .clk        (clk),
        .rst        (rst),
        .rd_pc      (rd_pc),
        .rd         (bht_rd),
        .upd_valid  (res_valid),
        .upd_pc     (res_pc),
        .upd_taken  (res_taken),
        .upd_target (res_target)
    );

    logic              ras_empty;
    addr_t             ras_top;
    logic [PTR_W-1:0]  ras_cur_ptr, ras_nxt_ptr;
    logic [CNT_W-1:0]  ras_cur_cnt, ras_nxt_cnt;
    logic [CKPT_W-1:0] ras_state;

    logic [SLOT_W-1:0] sel_slot;
    logic              sel_taken;
    addr_t             sel_next;
    logic              sel_push;
    logic              sel_pop;
    addr_t             sel_push_addr;

    bpred_select #(
        .NSLOT  (NSLOT),
        .SLOT_W (SLOT_W)
    ) u_sel (
        .slots     (slots),
        .pc        (fetch_pc),
        .bht       (bht_rd),
        .ras_empty (ras_empty),
        .ras_top   (ras_top),
        .slot_idx  (sel_slot),
        .taken     (sel_taken),
        .next_pc   (sel_next),
        .push      (sel_push),
        .push_addr (sel_push_addr),
        .pop       (sel_pop)
    );

    bpred_ras #(
        .DEPTH (RAS_DEPTH),
        .PTR_W (PTR_W),
        .CNT_W (CNT_W)
    ) u_ras (
        .clk         (clk),
        .rst         (rst),
        .push        (accept && sel_push),
        .push_addr   (sel_push_addr),
        .pop         (accept && sel_pop),
        .restore     (flush),
        .restore_ptr (res_ckpt[PTR_W-1:0]),
        .restore_cnt (res_ckpt[CKPT_W-1:PTR_W]),
        .top_addr    (ras_top),
        .empty       (ras_empty),
        .cur_ptr     (ras_cur_ptr),
        .cur_cnt     (ras_cur_cnt),
        .nxt_ptr     (ras_nxt_ptr),
        .nxt_cnt     (ras_nxt_cnt)
    );

    assign ras_state = {ras_cur_cnt, ras_cur_ptr};

    always_ff @(posedge clk) begin
        if (rst) begin
            pred_valid   <= 1'b0;
            pred_taken   <= 1'b0;
            pred_slot    <= '0;
            pred_next_pc <= '0;
            pred_ckpt    <= '0;
        end else begin
            pred_valid <= accept;
            if (accept) begin
                pred_taken   <= sel_taken;
                pred_slot    <= sel_slot;
                pred_next_pc <= sel_next;
                pred_ckpt    <= {ras_nxt_cnt, ras_nxt_ptr};
            end
        end
    end

endmodule

// File: rtl/bpred_checker.sv
module bpred_checker #(
    parameter int NSLOT     = 2,
    parameter int RAS_DEPTH = 8,
    parameter int PTR_W     = 3,
    parameter int CKPT_W    = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [31:0]       fetch_pc,
    input logic              res_valid,
    input logic              res_mispredict,
    input logic [CKPT_W-1:0] res_ckpt,
    input logic              pred_valid,
    input logic              pred_taken,
    input logic [31:0]       pred_next_pc,
    input logic [CKPT_W-1:0] ras_state
);

    logic        flush;
    logic [31:0] pc_q;
    logic [31:0] step;

    assign flush = res_valid && res_mispredict;
    assign step  = pred_next_pc - pc_q;

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= fetch_pc;
    end

    assert_flush_drop_R10: assert property (@(posedge clk) disable iff (rst)
        flush |=> !pred_valid);

    assert_ckpt_restore_R10: assert property (@(posedge clk) disable iff (rst)
        flush |=> (ras_state == $past(res_ckpt)));

    assert_one_cycle_R11: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !flush) |=> pred_valid);

    assert_idle_silent_R11: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !pred_valid);

    assert_idle_stack_R11: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !flush) |=> $stable(ras_state));

    assert_seq_next_R2: assert property (@(posedge clk) disable iff (rst)
        (pred_valid && !pred_taken) |->
            (step[1:0] == 2'b00 && step != 32'd0 && step <= 32'(4 * NSLOT)));

    assert_depth_bound_R8: assert property (@(posedge clk) disable iff (rst)
        ras_state[CKPT_W-1:PTR_W] <= (CKPT_W - PTR_W)'(RAS_DEPTH));

endmodule

bind bpred_top bpred_checker #(
    .NSLOT     (NSLOT),
    .RAS_DEPTH (RAS_DEPTH),
    .PTR_W     (PTR_W),
    .CKPT_W    (CKPT_W)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .in_valid       (in_valid),
    .fetch_pc       (fetch_pc),
    .res_valid      (res_valid),
    .res_mispredict (res_mispredict),
    .res_ckpt       (res_ckpt),
    .pred_valid     (pred_valid),
    .pred_taken     (pred_taken),
    .pred_next_pc   (pred_next_pc),
    .ras_state      (ras_state)
);

// File: tb/bpred_top_tb_top.sv
module bpred_top_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] fetch_pc;
    logic [1:0]  slot_valid, slot_branch, slot_call, slot_ldpc;
    logic [7:0]  slot_base;
    logic        res_valid;
    logic [31:0] res_pc;
    logic        res_taken;
    logic [31:0] res_target;
    logic        res_mispredict;
    logic [6:0]  res_ckpt;
    logic        pred_valid;
    logic        pred_taken;
    logic [0:0]  pred_slot;
    logic [31:0] pred_next_pc;
    logic [6:0]  pred_ckpt;

    always #2.5 clk = ~clk;

    bpred_top dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .fetch_pc(fetch_pc),
        .slot_valid(slot_valid), .slot_branch(slot_branch), .slot_call(slot_call),
        .slot_ldpc(slot_ldpc), .slot_base(slot_base),
        .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
        .res_target(res_target), .res_mispredict(res_mispredict), .res_ckpt(res_ckpt),
        .pred_valid(pred_valid), .pred_taken(pred_taken), .pred_slot(pred_slot),
        .pred_next_pc(pred_next_pc), .pred_ckpt(pred_ckpt)
    );

    int    tests_run    = 0;
    int    tests_failed = 0;
    bit    finished     = 1'b0;
    logic        exp_taken_q [$];
    logic [31:0] exp_next_q  [$];
    string       exp_tag_q   [$];
    logic [6:0]  last_ckpt;

    // Scoreboard monitor: compares each prediction against the queued expectation.
    always @(negedge clk) begin
        if (!rst && pred_valid) begin
            tests_run++;
            if (exp_next_q.size() == 0) begin
                tests_failed++;
                $display("FAIL R11 unexpected prediction: actual next=%h expected none", pred_next_pc);
            end else begin
                logic        et;
                logic [31:0] en;
                string       tg;
                et = exp_taken_q.pop_front();
                en = exp_next_q.pop_front();
                tg = exp_tag_q.pop_front();
                if (pred_taken !== et || pred_next_pc !== en) begin
                    tests_failed++;
                    $display("FAIL %s: actual taken=%0b next=%h expected taken=%0b next=%h",
                             tg, pred_taken, pred_next_pc, et, en);
                end
            end
            last_ckpt = pred_ckpt;
        end
    end

    task automatic drive(input logic [31:0] pc, input logic [1:0] v, input logic [1:0] br,
                         input logic [1:0] cl, input logic [1:0] lp, input logic [7:0] base,
                         input logic et, input logic [31:0] en, input string tg);
        @(negedge clk);
        in_valid = 1'b1; fetch_pc = pc; slot_valid = v; slot_branch = br;
        slot_call = cl; slot_ldpc = lp; slot_base = base;
        res_valid = 1'b0; res_mispredict = 1'b0;
        exp_taken_q.push_back(et);
        exp_next_q.push_back(en);
        exp_tag_q.push_back(tg);
    endtask

    task automatic resolve(input logic [31:0] pc, input logic tk, input logic [31:0] tgt);
        @(negedge clk);
        in_valid = 1'b0;
        res_valid = 1'b1; res_pc = pc; res_taken = tk; res_target = tgt;
        res_mispredict = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0; res_valid = 1'b0; res_mispredict = 1'b0;
        end
    endtask

    task automatic check_bit(input logic act, input logic exp, input string tg);
        tests_run++;
        if (act !== exp) begin
            tests_failed++;
            $display("FAIL %s: actual=%0b expected=%0b", tg, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        tests_run++;
        tests_failed++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [6:0] saved;
        rst = 1'b1; in_valid = 1'b0; fetch_pc = '0; slot_valid = '0; slot_branch = '0;
        slot_call = '0; slot_ldpc = '0; slot_base = '0; res_valid = 1'b0; res_pc = '0;
        res_taken = 1'b0; res_target = '0; res_mispredict = 1'b0; res_ckpt = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_bit(pred_valid, 1'b0, "R1 reset pred_valid");

        // R1/R2: empty table, direct branch in slot 0 -> sequential
        drive(32'h1000, 2'b11, 2'b01, 2'b00, 2'b00, 8'hFF, 1'b0, 32'h1008, "R2 miss not taken");
        // R3: allocate taken -> counter 2
        resolve(32'h1000, 1'b1, 32'h2000);
        drive(32'h1000, 2'b11, 2'b01, 2'b00, 2'b00, 8'hFF, 1'b1, 32'h2000, "R3 alloc taken");
        resolve(32'h1000, 1'b1, 32'h2000);
        resolve(32'h1000, 1'b1, 32'h2000);
        resolve(32'h1000, 1'b1, 32'h2000);   // saturates at 3
        resolve(32'h1000, 1'b0, 32'h0);      // 3 -> 2
        drive(32'h1000, 2'b11, 2'b01, 2'b00, 2'b00, 8'hFF, 1'b1, 32'h2000, "R3 saturate high");
        resolve(32'h1000, 1'b0, 32'h0);      // 2 -> 1
        drive(32'h1000, 2'b11, 2'b01, 2'b00, 2'b00, 8'hFF, 1'b0, 32'h1008, "R3 weak not taken");
        // R3: same index, other tag
        resolve(32'h1000, 1'b1, 32'h2000);   // 1 -> 2
        drive(32'h1100, 2'b11, 2'b01, 2'b00, 2'b00, 8'hFF, 1'b0, 32'h1108, "R3 tag mismatch");

        // R7: two branches; slot1 call must not push
        drive(32'h3000, 2'b11, 2'b11, 2'b10, 2'b00, 8'hFF, 1'b0, 32'h3004, "R7 refetch slot1");
        drive(32'h3100, 2'b11, 2'b01, 2'b00, 2'b00, 8'hFE, 1'b0, 32'h3108, "R7 second branch no push");
        // R7: invalid slot ignored
        drive(32'h3200, 2'b10, 2'b01, 2'b01, 2'b00, 8'hFF, 1'b0, 32'h3208, "R7 invalid slot");
        drive(32'h3300, 2'b11, 2'b01, 2'b00, 2'b00, 8'hFE, 1'b0, 32'h3308, "R9 empty return");

        // R4/R5/R6
        drive(32'h4000, 2'b11, 2'b10, 2'b10, 2'b00, 8'hFF, 1'b0, 32'h4008, "R4 call slot1");
        drive(32'h5000, 2'b11, 2'b01, 2'b01, 2'b00, 8'hFF, 1'b0, 32'h5008, "R4 call slot0");
        idle(3);
        check_bit(pred_valid, 1'b0, "R11 idle no prediction");
        drive(32'h6100, 2'b11, 2'b01, 2'b00, 2'b00, 8'hF3, 1'b0, 32'h6108, "R6 indirect r3");
        drive(32'h6000, 2'b11, 2'b01, 2'b00, 2'b00, 8'hFE, 1'b1, 32'h5004, "R5 lr return");
        drive(32'h6200, 2'b11, 2'b00, 2'b00, 2'b01, 8'hFD, 1'b1, 32'h4008, "R5 sp pop");
        drive(32'h6300, 2'b11, 2'b01, 2'b00, 2'b00, 8'hFE, 1'b0, 32'h6308, "R9 drained");

        // R8: nine calls, overflow drops the oldest
        for (int i = 0; i < 9; i++) begin
            drive(32'h8000 + 32'(16 * i), 2'b11, 2'b01, 2'b01, 2'b00, 8'hFF,
                  1'b0, 32'h8008 + 32'(16 * i), "R8 call");
        end
        for (int k = 8; k >= 1; k--) begin
            drive(32'h8800, 2'b11, 2'b01, 2'b00, 2'b00, 8'hFE,
                  1'b1, 32'h8004 + 32'(16 * k), "R8 lifo return");
        end
        drive(32'h8800, 2'b11, 2'b01, 2'b00, 2'b00, 8'hFE, 1'b0, 32'h8808, "R8 oldest lost");

        // R10: rewind after the entry was consumed
        drive(32'h9000, 2'b11, 2'b01, 2'b01, 2'b00, 8'hFF, 1'b0, 32'h9008, "R10 call");
        idle(2);
        saved = last_ckpt;
        drive(32'h9100, 2'b11, 2'b01, 2'b00, 2'b00, 8'hFE, 1'b1, 32'h9004, "R10 pop");
        idle(2);
        @(negedge clk);
        in_valid = 1'b1; fetch_pc = 32'h9300; slot_valid = 2'b11; slot_branch = 2'b01;
        slot_call = 2'b00; slot_ldpc = 2'b00; slot_base = 8'hFE;
        res_valid = 1'b1; res_mispredict = 1'b1; res_pc = 32'h9000; res_taken = 1'b1;
        res_target = 32'hA000; res_ckpt = saved;
        @(negedge clk);
        check_bit(pred_valid, 1'b0, "R10 flushed pair dropped");
        in_valid = 1'b0; res_valid = 1'b0; res_mispredict = 1'b0;
        drive(32'h9200, 2'b11, 2'b01, 2'b00, 2'b00, 8'hFE, 1'b1, 32'h9004, "R10 restored top");
        idle(3);
        check_bit(pred_valid, 1'b0, "R11 idle after drain");
        tests_run++;
        if (exp_next_q.size() != 0) begin
            tests_failed++;
            $display("FAIL R11 missing predictions: actual=%0d pending expected=0", exp_next_q.size());
        end
        finish_run();
    end

endmodule